// File: doc/BRIEF.md
# Four-Channel DAC Control Register Bank

This block keeps the digital control state of a four-channel digital-to-analog converter. It receives commands that a serial front end has already decoded: an opcode, a channel address, a data word and a strobe. It also receives a frame-active level, a functional clear, a load strobe and a supply-low indicator. Each channel holds a code and a 4-bit span in two stages. An input stage is written by commands, and an active stage drives the converter. Update commands or the load strobe copy the input stage into the active stage.

Clear zeroes only the active stage and leaves the input stage alone, so a later update brings the earlier outputs back. Non-read commands are held pending while a frame is open and are committed only when the frame closes. A clear that arrives while a command is pending cancels that command and marks the addressed channels as suspect. An active-low integrity flag stays asserted until a valid update runs. Channels sleep on command, and each pair of channels shares a reference amplifier that switches off only when both channels of the pair sleep.

Top module: `dacctl_regbank`

## Requirements
- R1: After reset, all input-stage and active-stage codes are 0 and all spans are 0000 (the 5 V unipolar range). All channels are awake, both amplifier enables are 1, `rflag_n` is 0, `rd_word` is 0 and every suspect bit is 0.
- R2: While `clr_n` is low, the active code and span of every channel are 0 from the next clock. Any pending command is discarded. The input stages keep their contents.
- R3: After a clear, an update command (opcode 0100) to an address copies the input stage of the addressed channels into their active stage. A one-clock `load_p` pulse does the same for all four channels. Either one restores the outputs held before the clear.
- R4: If `clr_n` is low while a command is pending, nothing from that command is committed, and the suspect bit of each channel it addressed is set. A suspect bit is cleared when a code or span write (opcode 0010, 0011 or 0110) to that channel commits.
- R5: `rflag_n` is driven low by reset, by a clear and by `supply_low`, and then stays low. It returns to 1 only in the clock after a valid update: opcode 0100 or 0110 to a valid address, or `load_p`. When a release and `supply_low` come in the same cycle, `supply_low` wins.
- R6: The opcodes are as follows. 0010 writes the input span from `cmd_data[3:0]`. 0011 writes the input code. 0100 updates. 0110 writes the input code and updates. 1100 reads back. 1110 sleeps. Any other opcode changes nothing and does not release `rflag_n`.
- R7: Addresses 0000 to 0011 select channels A to D. Address 1111 selects all four channels. Any other address selects nothing, and an update sent to such an address does not count as a valid update.
- R8: A non-read command is captured on `cmd_vld` and waits while `frame_act` is 1. It executes in the first clock in which it is pending and `frame_act` is 0, and its effect shows at the next clock.
- R9: Opcode 1110 puts the addressed channels to sleep. Opcode 0100 or 0110 wakes the addressed channels, and `load_p` wakes all four.
- R10: `amp_en[0]` is 0 only when channels A and B both sleep. `amp_en[1]` is 0 only when channels C and D both sleep. Either enable stays 1 if only one channel of its pair sleeps.
- R11: A read (opcode 1100 with `cmd_vld`, address 0000 to 0011) loads `rd_word` one clock later. The word carries the active span in bits 3:0 and the sleep bit in bit 4 (1 means asleep), with bits 15:5 at zero. A read to any other address leaves `rd_word` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| clr_n | input | 1 | Active-low system clear, sampled each clock |
| frame_act | input | 1 | High while a command frame is open |
| cmd_vld | input | 1 | Decoded-command strobe |
| cmd_op | input | 4 | Command opcode |
| cmd_addr | input | 4 | Channel address |
| cmd_data | input | CODE_W | Command data |
| load_p | input | 1 | Load strobe, updates all channels |
| supply_low | input | 1 | Logic supply low indicator |
| code_act | output | 4*CODE_W | Active codes, channel A in the low bits |
| span_act | output | 16 | Active spans, 4 bits per channel |
| slp | output | 4 | Sleep state per channel |
| amp_en | output | 2 | Shared reference amplifier enables (A/B, C/D) |
| susp | output | 4 | Per-channel suspect input stage |
| rd_word | output | 16 | Readback word |
| rflag_n | output | 1 | Active-low data-integrity flag |

## Verification
The hardest state to reach is a clear that lands inside an open frame after a command has been captured but before it commits. In that state the cancelled data must never appear, and the suspect bit must be set. The bench holds `frame_act` high across the strobe and pulls `clr_n` low in the following cycle, before the frame closes. It then pulses the load strobe to show that the active stage holds the old input contents and not the cancelled data. A second corner is a supply-low pulse in the same cycle as a load, which must leave the flag low.

// File: rtl/dacctl_pkg.sv
package dacctl_pkg;
  localparam int NCH   = 4;
  localparam int NPAIR = NCH / 2;
  localparam int SPW   = 4;
  localparam int OPW   = 4;
  localparam int AW    = 4;
  localparam int RDW   = 16;

  localparam logic [OPW-1:0] OP_WR_SPAN = 4'b0010;
  localparam logic [OPW-1:0] OP_WR_CODE = 4'b0011;
  localparam logic [OPW-1:0] OP_UPD     = 4'b0100;
  localparam logic [OPW-1:0] OP_WR_UPD  = 4'b0110;
  localparam logic [OPW-1:0] OP_RD_SPAN = 4'b1100;
  localparam logic [OPW-1:0] OP_SLEEP   = 4'b1110;
  localparam logic [AW-1:0]  ADDR_ALL   = 4'b1111;

  // One-hot channel mask for an address, all ones for the broadcast address.
  function automatic logic [NCH-1:0] addr_mask(input logic [AW-1:0] a);
    logic [NCH-1:0] m;
    m = '0;
    if (a == ADDR_ALL) m = '1;
    else if (a < AW'(NCH)) m[a[1:0]] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/dacctl_cmd.sv
module dacctl_cmd
  import dacctl_pkg::*;
#(
  parameter int CODE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_n,
  input  logic              frame_act,
  input  logic              cmd_vld,
  input  logic [OPW-1:0]    cmd_op,
  input  logic [AW-1:0]     cmd_addr,
  input  logic [CODE_W-1:0] cmd_data,
  output logic [NCH-1:0]    ex_wr_span,
  output logic [NCH-1:0]    ex_wr_code,
  output logic [NCH-1:0]    ex_upd,
  output logic [NCH-1:0]    ex_sleep,
  output logic [CODE_W-1:0] ex_data,
  output logic              ex_valid_upd,
  output logic [NCH-1:0]    abort_mask,
  output logic              rd_go,
  output logic [1:0]        rd_ch
);
  logic              pend_vld_q, pend_vld_d;
  logic [OPW-1:0]    pend_op_q, pend_op_d;
  logic [AW-1:0]     pend_addr_q, pend_addr_d;
  logic [CODE_W-1:0] pend_data_q, pend_data_d;
  logic              exec, is_rd;
  logic [NCH-1:0]    mask;

  assign is_rd = (cmd_op == OP_RD_SPAN);
  assign exec  = pend_vld_q && !frame_act && clr_n;
  assign mask  = addr_mask(pend_addr_q);

  always_comb begin
    pend_vld_d  = pend_vld_q;
    pend_op_d   = pend_op_q;
    pend_addr_d = pend_addr_q;
    pend_data_d = pend_data_q;
    if (!clr_n) begin
      pend_vld_d  = 1'b0;
      pend_op_d   = '0;
      pend_addr_d = '0;
      pend_data_d = '0;
    end else begin
      if (exec) pend_vld_d = 1'b0;
      if (cmd_vld && !is_rd) begin
        pend_vld_d  = 1'b1;
        pend_op_d   = cmd_op;
        pend_addr_d = cmd_addr;
        pend_data_d = cmd_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld_q  <= 1'b0;
      pend_op_q   <= '0;
      pend_addr_q <= '0;
      pend_data_q <= '0;
    end else begin
      pend_vld_q  <= pend_vld_d;
      pend_op_q   <= pend_op_d;
      pend_addr_q <= pend_addr_d;
      pend_data_q <= pend_data_d;
    end
  end

  always_comb begin
    ex_wr_span = '0;
    ex_wr_code = '0;
    ex_upd     = '0;
    ex_sleep   = '0;
    if (exec) begin
      unique case (pend_op_q)
        OP_WR_SPAN: ex_wr_span = mask;
        OP_WR_CODE: ex_wr_code = mask;
        OP_UPD:     ex_upd     = mask;
        OP_WR_UPD: begin
          ex_wr_code = mask;
          ex_upd     = mask;
        end
        OP_SLEEP:   ex_sleep   = mask;
        default: ;
      endcase
    end
  end

  assign ex_data      = pend_data_q;
  assign ex_valid_upd = |ex_upd;
  assign abort_mask   = (!clr_n && pend_vld_q) ? mask : '0;
  assign rd_go        = cmd_vld && clr_n && is_rd && (cmd_addr < AW'(NCH));
  assign rd_ch        = cmd_addr[1:0];
endmodule

// File: rtl/dacctl_chan.sv
module dacctl_chan
  import dacctl_pkg::*;
#(
  parameter int CODE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_n,
  input  logic              wr_span,
  input  logic              wr_code,
  input  logic              upd,
  input  logic              abort,
  input  logic [CODE_W-1:0] din,
  output logic [CODE_W-1:0] code_act,
  output logic [SPW-1:0]    span_act,
  output logic              susp
);
  logic [CODE_W-1:0] code_in_q, code_in_d, code_act_q, code_act_d;
  logic [SPW-1:0]    span_in_q, span_in_d, span_act_q, span_act_d;
  logic              susp_q, susp_d;

  always_comb begin
    code_in_d  = wr_code ? din : code_in_q;
    span_in_d  = wr_span ? din[SPW-1:0] : span_in_q;
    code_act_d = code_act_q;
    span_act_d = span_act_q;
    if (!clr_n) begin
      code_act_d = '0;
      span_act_d = '0;
    end else if (upd) begin
      code_act_d = code_in_d;
      span_act_d = span_in_d;
    end
    susp_d = susp_q;
    if (wr_code || wr_span) susp_d = 1'b0;
    else if (abort)         susp_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_in_q  <= '0;
      span_in_q  <= '0;
      code_act_q <= '0;
      span_act_q <= '0;
      susp_q     <= 1'b0;
    end else begin
      code_in_q  <= code_in_d;
      span_in_q  <= span_in_d;
      code_act_q <= code_act_d;
      span_act_q <= span_act_d;
      susp_q     <= susp_d;
    end
  end

  assign code_act = code_act_q;
  assign span_act = span_act_q;
  assign susp     = susp_q;
endmodule

// File: rtl/dacctl_pwr.sv
module dacctl_pwr
  import dacctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   sleep_set,
  input  logic [NCH-1:0]   wake,
  output logic [NCH-1:0]   slp,
  output logic [NPAIR-1:0] amp_en
);
  logic [NCH-1:0] slp_q, slp_d;

  always_comb begin
    slp_d = (slp_q & ~wake) | sleep_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slp_q <= '0;
    else        slp_q <= slp_d;
  end

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    assign amp_en[p] = !(slp_q[2*p] && slp_q[2*p+1]);
  end

  assign slp = slp_q;
endmodule

// File: rtl/dacctl_regbank.sv
module dacctl_regbank
  import dacctl_pkg::*;
#(
  parameter int CODE_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr_n,
  input  logic                  frame_act,
  input  logic                  cmd_vld,
  input  logic [3:0]            cmd_op,
  input  logic [3:0]            cmd_addr,
  input  logic [CODE_W-1:0]     cmd_data,
  input  logic                  load_p,
  input  logic                  supply_low,
  output logic [4*CODE_W-1:0]   code_act,
  output logic [15:0]           span_act,
  output logic [3:0]            slp,
  output logic [1:0]            amp_en,
  output logic [3:0]            susp,
  output logic [15:0]           rd_word,
  output logic                  rflag_n
);
  logic [NCH-1:0]    ex_wr_span, ex_wr_code, ex_upd, ex_sleep, abort_mask;
  logic [NCH-1:0]    upd_all;
  logic [CODE_W-1:0] ex_data;
  logic              ex_valid_upd, rd_go, load_go;
  logic [1:0]        rd_ch;
  logic [SPW-1:0]    span_a [NCH];
  logic [RDW-1:0]    rd_q, rd_d;
  logic              flag_q, flag_d;

  dacctl_cmd #(.CODE_W(CODE_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .frame_act(frame_act),
    .cmd_vld(cmd_vld), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .ex_wr_span(ex_wr_span), .ex_wr_code(ex_wr_code), .ex_upd(ex_upd),
    .ex_sleep(ex_sleep), .ex_data(ex_data), .ex_valid_upd(ex_valid_upd),
    .abort_mask(abort_mask), .rd_go(rd_go), .rd_ch(rd_ch)
  );

  assign load_go = load_p && clr_n;
  assign upd_all = ex_upd | {NCH{load_go}};

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dacctl_chan #(.CODE_W(CODE_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .clr_n(clr_n),
      .wr_span(ex_wr_span[i]), .wr_code(ex_wr_code[i]), .upd(upd_all[i]),
      .abort(abort_mask[i]), .din(ex_data),
      .code_act(code_act[i*CODE_W +: CODE_W]),
      .span_act(span_a[i]), .susp(susp[i])
    );
    assign span_act[i*SPW +: SPW] = span_a[i];
  end

  dacctl_pwr u_pwr (
    .clk(clk), .rst_n(rst_n), .sleep_set(ex_sleep), .wake(upd_all),
    .slp(slp), .amp_en(amp_en)
  );

  // Integrity flag: set state 0, released by a valid update.
  always_comb begin
    flag_d = flag_q;
    if (!clr_n || supply_low)        flag_d = 1'b0;
    else if (ex_valid_upd || load_go) flag_d = 1'b1;
  end

  always_comb begin
    rd_d = rd_q;
    if (rd_go) rd_d = {{(RDW-SPW-1){1'b0}}, slp[rd_ch], span_a[rd_ch]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      rd_q   <= '0;
    end else begin
      flag_q <= flag_d;
      rd_q   <= rd_d;
    end
  end

  assign rflag_n = flag_q;
  assign rd_word = rd_q;
endmodule

// File: rtl/dacctl_regbank_chk.sv
module dacctl_regbank_chk #(
  parameter int CODE_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                clr_n,
  input logic                supply_low,
  input logic [4*CODE_W-1:0] code_act,
  input logic [15:0]         span_act,
  input logic [3:0]          slp,
  input logic [1:0]          amp_en,
  input logic [15:0]         rd_word,
  input logic                rflag_n
);
  AST_CLR_ZEROES_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> (code_act == '0 && span_act == '0)); // R2
  AST_FLAG_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> !rflag_n); // R5
  AST_FLAG_ON_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
    supply_low |=> !rflag_n); // R5
  AST_FLAG_RELEASE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rflag_n) |-> ($past(clr_n) && !$past(supply_low))); // R5
  AST_AMP_AB_ONE_SLEEPER: assert property (@(posedge clk) disable iff (!rst_n)
    (slp[0] ^ slp[1]) |-> amp_en[0]); // R10
  AST_AMP_CD_ONE_SLEEPER: assert property (@(posedge clk) disable iff (!rst_n)
    (slp[2] ^ slp[3]) |-> amp_en[1]); // R10
  AST_AMP_AB_OFF_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    !amp_en[0] |-> (slp[0] && slp[1])); // R10
  AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_word[15:5] == '0); // R11
endmodule

bind dacctl_regbank dacctl_regbank_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .supply_low(supply_low),
  .code_act(code_act), .span_act(span_act), .slp(slp), .amp_en(amp_en),
  .rd_word(rd_word), .rflag_n(rflag_n)
);

// File: tb/dacctl_regbank_tb.sv
module dacctl_regbank_tb;
  localparam int CW = 16;
  localparam logic [3:0] WSPAN = 4'b0010, WCODE = 4'b0011, UPD = 4'b0100,
                         WUPD = 4'b0110, RD = 4'b1100, SLP = 4'b1110, ALL = 4'b1111;

  logic clk = 1'b0;
  logic rst_n = 1'b0, clr_n = 1'b1, frame_act = 1'b0, cmd_vld = 1'b0;
  logic [3:0] cmd_op = '0, cmd_addr = '0;
  logic [CW-1:0] cmd_data = '0;
  logic load_p = 1'b0, supply_low = 1'b0;
  logic [4*CW-1:0] code_act;
  logic [15:0] span_act, rd_word;
  logic [3:0] slp, susp;
  logic [1:0] amp_en;
  logic rflag_n;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dacctl_regbank #(.CODE_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .frame_act(frame_act),
    .cmd_vld(cmd_vld), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .load_p(load_p), .supply_low(supply_low), .code_act(code_act),
    .span_act(span_act), .slp(slp), .amp_en(amp_en), .susp(susp),
    .rd_word(rd_word), .rflag_n(rflag_n)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [3:0] op, input logic [3:0] addr, input logic [CW-1:0] d);
    @(negedge clk);
    frame_act = 1'b1; cmd_vld = 1'b1; cmd_op = op; cmd_addr = addr; cmd_data = d;
    @(negedge clk);
    cmd_vld = 1'b0; frame_act = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [3:0] addr);
    @(negedge clk);
    cmd_vld = 1'b1; cmd_op = RD; cmd_addr = addr;
    @(negedge clk);
    cmd_vld = 1'b0;
  endtask

  task automatic load();
    @(negedge clk); load_p = 1'b1;
    @(negedge clk); load_p = 1'b0;
  endtask

  task automatic clear();
    @(negedge clk); clr_n = 1'b0;
    @(negedge clk); clr_n = 1'b1;
  endtask

  task automatic t_reset();
    chk("R1 code", code_act, 64'h0);
    chk("R1 span", span_act, 64'h0);
    chk("R1 sleep/amp", {slp, amp_en}, {4'h0, 2'b11});
    chk("R1 flag", rflag_n, 1'b0);
    chk("R1 rd/susp", {rd_word, susp}, 20'h0);
  endtask

  task automatic t_write_update();
    cmd(WCODE, 4'd0, 16'h1111);
    chk("R6 input-only write", code_act, 64'h0);
    chk("R5 flag held after write", rflag_n, 1'b0);
    @(negedge clk);
    frame_act = 1'b1; cmd_vld = 1'b1; cmd_op = WUPD; cmd_addr = 4'd1; cmd_data = 16'h2222;
    @(negedge clk); cmd_vld = 1'b0;
    @(negedge clk);
    chk("R8 held while frame open", code_act, 64'h0);
    frame_act = 1'b0;
    @(negedge clk);
    chk("R8 commit after frame", code_act, 64'h0000_0000_2222_0000);
    chk("R5 released by update", rflag_n, 1'b1);
    cmd(UPD, 4'd0, '0);
    chk("R6 update ch A", code_act, 64'h0000_0000_2222_1111);
    cmd(WSPAN, 4'd2, 16'h0005);
    cmd(WCODE, 4'd3, 16'h3333);
    cmd(UPD, ALL, '0);
    chk("R7 broadcast code", code_act, 64'h3333_0000_2222_1111);
    chk("R7 broadcast span", span_act, 64'h0500);
  endtask

  task automatic t_clear_restore();
    clear();
    chk("R2 active zeroed", {code_act, span_act}, 80'h0);
    chk("R5 flag on clear", rflag_n, 1'b0);
    cmd(UPD, 4'd1, '0);
    chk("R3 addressed restore", code_act, 64'h0000_0000_2222_0000);
    load();
    chk("R3 load restore code", code_act, 64'h3333_0000_2222_1111);
    chk("R3 load restore span", span_act, 64'h0500);
  endtask

  task automatic t_flag();
    @(negedge clk); supply_low = 1'b1;
    @(negedge clk); supply_low = 1'b0;
    chk("R5 flag on supply low", rflag_n, 1'b0);
    cmd(4'b0101, 4'd0, 16'hFFFF);
    chk("R6 unknown opcode ignored", {rflag_n, code_act}, {1'b0, 64'h3333_0000_2222_1111});
    cmd(UPD, 4'd7, '0);
    chk("R7 bad address no release", rflag_n, 1'b0);
    cmd(WCODE, 4'd8, 16'hBEEF);
    load();
    chk("R7 bad address write ignored", code_act, 64'h3333_0000_2222_1111);
    chk("R5 released by load", rflag_n, 1'b1);
    @(negedge clk); supply_low = 1'b1; load_p = 1'b1;
    @(negedge clk); supply_low = 1'b0; load_p = 1'b0;
    chk("R5 supply low wins", rflag_n, 1'b0);
  endtask

  task automatic t_abort();
    @(negedge clk);
    frame_act = 1'b1; cmd_vld = 1'b1; cmd_op = WCODE; cmd_addr = 4'd2; cmd_data = 16'hDEAD;
    @(negedge clk); cmd_vld = 1'b0; clr_n = 1'b0;
    @(negedge clk); clr_n = 1'b1; frame_act = 1'b0;
    @(negedge clk);
    chk("R4 suspect set", susp, 4'b0100);
    load();
    chk("R4 nothing committed", code_act, 64'h3333_0000_2222_1111);
    cmd(WSPAN, 4'd2, 16'h0007);
    chk("R4 suspect cleared by write", susp, 4'b0000);
  endtask

  task automatic t_sleep_amp();
    cmd(SLP, 4'd0, '0);
    chk("R10 one sleeper keeps amp", {slp, amp_en}, {4'b0001, 2'b11});
    rd(4'd0);
    chk("R11 sleep bit readback", rd_word, 16'h0010);
    cmd(SLP, 4'd1, '0);
    chk("R10 pair asleep", {slp, amp_en}, {4'b0011, 2'b10});
    cmd(UPD, 4'd1, '0);
    chk("R9 update wakes", {slp, amp_en}, {4'b0001, 2'b11});
    cmd(SLP, ALL, '0);
    chk("R9 sleep all", {slp, amp_en}, {4'b1111, 2'b00});
    load();
    chk("R9 load wakes all", {slp, amp_en}, {4'b0000, 2'b11});
  endtask

  task automatic t_readback();
    @(negedge clk);
    cmd_vld = 1'b1; cmd_op = RD; cmd_addr = 4'd2;
    #1 chk("R11 not before clock", rd_word, 16'h0010);
    @(negedge clk); cmd_vld = 1'b0;
    chk("R11 span readback", rd_word, 16'h0007);
    rd(ALL);
    chk("R11 broadcast read ignored", rd_word, 16'h0007);
    cmd(SLP, 4'd3, '0);
    rd(4'd3);
    chk("R11 sleeping ch D", rd_word, 16'h0010);
    chk("R10 only D asleep", amp_en, 2'b11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_update();
    t_clear_restore();
    t_flag();
    t_abort();
    t_sleep_amp();
    t_readback();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule